// File: doc/BRIEF.md
# Eight-Channel Serial Switch Controller

This block is a serial slave that sets eight low-side switch enables from an 8-bit command. It also returns the sensed drain level of every channel to the host. The host pulls chip select low and clocks in one byte, most significant bit first. When chip select returns high, the byte becomes the new switch state. During the same frame, the drain levels sampled when the frame opened shift out on the serial output.

Each channel carries over-current protection. With the protect-disable input low, an over-current turns off only the affected channel, and it stays off. With that input high, the channel stays on and relies on analog current limiting. It shuts off only when its over-temperature flag is also raised.

The serial inputs are brought into the system clock domain through synchronisers. The system clock must run at least four times faster than the serial clock.

Top module: `octal_switch_ctrl`

## Requirements
- R1: While rst_ni is low, every switch enable is 0. After reset is released they stay 0 until a valid frame is committed.
- R2: With cs_ni low, each rising sclk_i edge shifts in one sdi_i bit. On the cs_ni rising edge of a frame holding exactly 8 bits, sw_en_o[7-i] takes the i-th bit received, so the first bit received drives channel 7.
- R3: A frame holding fewer or more than 8 sclk_i rising edges, including a frame with none, leaves sw_en_o unchanged.
- R4: sdo_oe_o is 1 exactly while cs_ni is 0. It does not depend on the clock or on reset.
- R5: At the start of a frame the block captures drain_hi_i. sdo_o then presents bit 7 of that capture, a 1 meaning drain high. Each rising sclk_i edge advances sdo_o to the next lower channel, so the bit valid while sclk_i is low before the k-th rise (k from 0) is channel 7-k.
- R6: After the eight status bits, sdo_o continues with the sdi_i bits of the same frame in the order they arrived, first in first out.
- R7: With sfpd_i low, an over-current on an enabled channel turns that channel off at the next clock. The other channels are not affected.
- R8: With sfpd_i high, an enabled channel under over-current stays on. It turns off at the next clock once ot_i for that channel is also high.
- R9: A channel turned off by protection stays off after the fault clears. Only a valid frame that writes 1 to that channel turns it back on, and only if the fault is gone.
- R10: Pulsing rst_ni low in the middle of a frame does not disturb sdo_o or sdo_oe_o. The status bits of that frame still shift out correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the sclk_i rate |
| rst_ni | input | 1 | Active-low asynchronous reset of command and protection state |
| cs_ni | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock, data taken on rising edges |
| sdi_i | input | 1 | Serial command data, MSB first |
| sfpd_i | input | 1 | 1: keep channels on under over-current; 0: latch off on over-current |
| drain_hi_i | input | 8 | Per-channel drain level, 1 = high |
| oc_i | input | 8 | Per-channel over-current flag |
| ot_i | input | 8 | Per-channel over-temperature flag |
| sdo_o | output | 1 | Serial status data, MSB first |
| sdo_oe_o | output | 1 | Output enable for sdo_o (tri-state control) |
| sw_en_o | output | 8 | Switch enables, one per channel |

## Verification
The hardest situation to reach is a reset pulse in the middle of a frame. The status path has to keep shifting while the command side is cleared, and the cleared bit count then has to cause the truncated frame to be discarded. The bench gets there by raising reset between two serial clock edges inside a frame it is driving. It then checks the status byte it collects from sdo_o, and it checks that the switches are still off after chip select rises. A second hard case is a write of 1 to a channel whose over-current is still present. The bench commits such a frame while holding the fault, so that the channel is on for a single cycle, and then checks that it latches off again.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int unsigned CH_N = 8;

  typedef struct packed {
    logic cs_n;
    logic sck;
    logic sdi;
  } ser_t;
endpackage

// File: rtl/osc_sync.sv
module osc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i) begin
    stg_q[0] <= d_i;
    for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/osc_frame.sv
module osc_frame
  import osc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  ser_t         ser_i,
  input  logic [W-1:0] status_i,
  output logic         so_o,
  output logic [W-1:0] cmd_o,
  output logic         commit_o
);
  localparam int unsigned CNT_W   = $clog2(W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);

  ser_t             prev_q;
  logic             start, stop, tick;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     cmd_sh_q;
  logic [W-1:0]     so_sh_q;

  // edge detector and status path carry no reset: reset must not touch SO
  always_ff @(posedge clk_i) prev_q <= ser_i;

  assign start = prev_q.cs_n & ~ser_i.cs_n;
  assign stop  = ~prev_q.cs_n & ser_i.cs_n;
  assign tick  = ~ser_i.cs_n & ~prev_q.sck & ser_i.sck;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
    end else if (tick && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmd_sh_q <= '0;
    else if (tick) cmd_sh_q <= {cmd_sh_q[W-2:0], ser_i.sdi};
  end

  always_ff @(posedge clk_i) begin
    if (start)     so_sh_q <= status_i;
    else if (tick) so_sh_q <= {so_sh_q[W-2:0], ser_i.sdi};
  end

  assign so_o     = so_sh_q[W-1];
  assign cmd_o    = cmd_sh_q;
  assign commit_o = stop & (cnt_q == CNT_FULL);

  // R2: a frame commits at most once
  p_single_commit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
endmodule

// File: rtl/osc_chan.sv
module osc_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic commit_i,
  input  logic cmd_bit_i,
  input  logic sfpd_i,
  input  logic oc_i,
  input  logic ot_i,
  output logic en_o
);
  logic cmd_q, trip_q, trip_set;

  assign trip_set = en_o & oc_i & (~sfpd_i | ot_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= 1'b0;
      trip_q <= 1'b0;
    end else if (commit_i) begin
      cmd_q  <= cmd_bit_i;
      trip_q <= 1'b0;
    end else if (trip_set) begin
      trip_q <= 1'b1;
    end
  end

  assign en_o = cmd_q & ~trip_q;

  p_latch_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && oc_i && !sfpd_i && !commit_i) |=> !en_o);
  p_hold_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && oc_i && sfpd_i && !ot_i && !commit_i) |=> en_o);
  p_hot_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && oc_i && sfpd_i && ot_i && !commit_i) |=> !en_o);
endmodule

// File: rtl/octal_switch_ctrl.sv
module octal_switch_ctrl
  import osc_pkg::*;
#(
  parameter int unsigned CH     = CH_N,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          sclk_i,
  input  logic          sdi_i,
  input  logic          sfpd_i,
  input  logic [CH-1:0] drain_hi_i,
  input  logic [CH-1:0] oc_i,
  input  logic [CH-1:0] ot_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic [CH-1:0] sw_en_o
);
  localparam int unsigned SER_W = $bits(ser_t);

  ser_t          ser_raw, ser_s;
  logic [CH-1:0] cmd_word;
  logic          commit;

  assign ser_raw = '{cs_n: cs_ni, sck: sclk_i, sdi: sdi_i};

  osc_sync #(.W(SER_W), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .d_i   (ser_raw),
    .q_o   (ser_s)
  );

  osc_frame #(.W(CH)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ser_i    (ser_s),
    .status_i (drain_hi_i),
    .so_o     (sdo_o),
    .cmd_o    (cmd_word),
    .commit_o (commit)
  );

  for (genvar k = 0; k < CH; k++) begin : g_ch
    osc_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .commit_i  (commit),
      .cmd_bit_i (cmd_word[k]),
      .sfpd_i    (sfpd_i),
      .oc_i      (oc_i[k]),
      .ot_i      (ot_i[k]),
      .en_o      (sw_en_o[k])
    );
  end

  // tri-state control follows chip select only
  assign sdo_oe_o = ~cs_ni;

  // R3: no channel turns on without a committed frame
  p_no_turn_on_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> ((sw_en_o & ~$past(sw_en_o)) == '0));
endmodule

// File: tb/octal_switch_ctrl_tb_top.sv
module octal_switch_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, sfpd = 1'b0;
  logic [7:0] drain = '0, oc = '0, ot = '0;
  logic       sdo, sdo_oe;
  logic [7:0] sw_en;
  int         n_run = 0, n_fail = 0;
  logic [7:0] exp_en = '0;
  logic [15:0] cap;

  always #(CLK_PERIOD/2) clk = ~clk;

  octal_switch_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sck), .sdi_i(sdi),
    .sfpd_i(sfpd), .drain_hi_i(drain), .oc_i(oc), .ot_i(ot),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sw_en_o(sw_en)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] cmd, input int nbits, input int rst_bit,
                       output logic [15:0] so_cap);
    so_cap = '0;
    cs_n = 1'b0;
    wait_clk(HALF_SCK);
    chk(sdo_oe === 1'b1, "R4 oe in frame", {15'd0, sdo_oe}, 16'd1);
    for (int i = 0; i < nbits; i++) begin
      sdi = cmd[7 - (i % 8)];
      if (i == rst_bit) begin
        rst_n = 1'b0;
        wait_clk(2);
        chk(sdo_oe === 1'b1, "R10 oe during reset", {15'd0, sdo_oe}, 16'd1);
        rst_n = 1'b1;
      end
      wait_clk(HALF_SCK);
      if (i < 16) so_cap[15-i] = sdo;
      sck = 1'b1;
      wait_clk(HALF_SCK);
      sck = 1'b0;
    end
    wait_clk(HALF_SCK);
    cs_n = 1'b1;
    wait_clk(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_clk(4);
    // R1 reset state, R4 idle tri-state
    chk(sw_en === 8'h00, "R1 reset", {8'd0, sw_en}, 16'd0);
    chk(sdo_oe === 1'b0, "R4 idle oe", {15'd0, sdo_oe}, 16'd0);
    rst_n = 1'b1;
    wait_clk(4);
    chk(sw_en === 8'h00, "R1 after release", {8'd0, sw_en}, 16'd0);

    // R2/R5 sweep of every command with varied drain patterns
    for (int c = 0; c < 256; c++) begin
      drain = ~exp_en ^ 8'(c * 37);
      frame(8'(c), 8, -1, cap);
      chk(cap[15:8] === drain, "R5 status", {8'd0, cap[15:8]}, {8'd0, drain});
      exp_en = 8'(c);
      chk(sw_en === exp_en, "R2 command", {8'd0, sw_en}, {8'd0, exp_en});
    end
    drain = 8'h80;
    frame(8'h5A, 8, -1, cap);
    chk(cap[15:8] === 8'h80, "R5 channel 7 first", {8'd0, cap[15:8]}, 16'h0080);
    exp_en = 8'h5A;

    // R3 wrong bit counts
    frame(8'hFF, 7, -1, cap);
    chk(sw_en === exp_en, "R3 seven bits", {8'd0, sw_en}, {8'd0, exp_en});
    frame(8'hFF, 9, -1, cap);
    chk(sw_en === exp_en, "R3 nine bits", {8'd0, sw_en}, {8'd0, exp_en});
    frame(8'hFF, 0, -1, cap);
    chk(sw_en === exp_en, "R3 empty frame", {8'd0, sw_en}, {8'd0, exp_en});

    // R6 FIFO pass-through after status
    drain = 8'h0F;
    frame(8'hA5, 16, -1, cap);
    chk(cap[15:8] === 8'h0F, "R6 status head", {8'd0, cap[15:8]}, 16'h000F);
    chk(cap[7:0] === 8'hA5, "R6 fifo tail", {8'd0, cap[7:0]}, 16'h00A5);
    chk(sw_en === exp_en, "R3 sixteen bits", {8'd0, sw_en}, {8'd0, exp_en});

    // R7 and R9 latch-off with protection enabled
    sfpd = 1'b0;
    frame(8'hFF, 8, -1, cap);
    oc = 8'h08;
    wait_clk(3);
    chk(sw_en === 8'hF7, "R7 latch off", {8'd0, sw_en}, 16'h00F7);
    oc = 8'h00;
    wait_clk(5);
    chk(sw_en === 8'hF7, "R9 stays off", {8'd0, sw_en}, 16'h00F7);
    frame(8'hFF, 8, -1, cap);
    chk(sw_en === 8'hFF, "R9 rewrite", {8'd0, sw_en}, 16'h00FF);
    frame(8'h0F, 8, -1, cap);
    oc = 8'h80;
    wait_clk(3);
    chk(sw_en === 8'h0F, "R7 off channel unaffected", {8'd0, sw_en}, 16'h000F);
    frame(8'h8F, 8, -1, cap);
    chk(sw_en === 8'h0F, "R9 rewrite under fault", {8'd0, sw_en}, 16'h000F);
    oc = 8'h00;

    // R8 protect disabled
    frame(8'hFF, 8, -1, cap);
    sfpd = 1'b1;
    oc = 8'h20;
    wait_clk(20);
    chk(sw_en === 8'hFF, "R8 hold on", {8'd0, sw_en}, 16'h00FF);
    ot = 8'h20;
    wait_clk(3);
    chk(sw_en === 8'hDF, "R8 thermal off", {8'd0, sw_en}, 16'h00DF);
    oc = 8'h00;
    ot = 8'h00;
    sfpd = 1'b0;

    // R1 reset clears outputs
    rst_n = 1'b0;
    wait_clk(2);
    chk(sw_en === 8'h00, "R1 reset clears", {8'd0, sw_en}, 16'd0);
    rst_n = 1'b1;
    wait_clk(2);

    // R10 reset inside a frame
    frame(8'hFF, 8, -1, cap);
    drain = 8'h3C;
    frame(8'hFF, 8, 3, cap);
    chk(cap[15:8] === 8'h3C, "R10 status intact", {8'd0, cap[15:8]}, 16'h003C);
    chk(sw_en === 8'h00, "R10 truncated frame dropped", {8'd0, sw_en}, 16'd0);
    frame(8'h81, 8, -1, cap);
    chk(sw_en === 8'h81, "R2 after reset", {8'd0, sw_en}, 16'h0081);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule